// File: doc/BRIEF.md
# Two-Dimensional Strided Word Address Sequencer

This block walks a rectangular region of memory on behalf of one transfer channel and emits one word address per accepted cycle. It is configured with a starting word address, a line length, a line stride and a line count minus one. All of these values count 4-byte words. A start strobe captures the configuration. From then on, each cycle in which the output is valid and the downstream consumer is ready moves the sequencer one word forward.

A non-zero line length selects block mode. Each line emits the line-length number of consecutive words, and each new line begins one stride past the beginning of the previous line. After the final word of the final line, the block raises a one-cycle completion pulse and returns to idle.

A line length of zero selects circular mode. The area then spans stride × (line count + 1) words and is traversed linearly, wrapping to the start address at its end. A pulse marks the end of each half of the area on every pass. Circular mode runs only while the loop enable input is high, and it continues until a stop strobe arrives.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, valid_o, done_o and half_irq_o are all low.
- R2: In block mode the k-th accepted address equals start + (k div len)·stride + (k mod len), where len is the line length.
- R3: Block mode emits exactly len·(line count + 1) addresses, so a line count of 0 gives a single line.
- R4: The address moves forward only on a cycle where valid_o and ready_i are both high. While ready_i is low, addr_o holds its value.
- R5: done_o pulses high for exactly one cycle. The pulse comes in the cycle after the handshake of the final block-mode address, and valid_o is low from that cycle on.
- R6: A line length of 0 at start selects circular mode. The k-th accepted address is start + (k mod A), where A = stride·(line count + 1). done_o never rises in this mode.
- R7: In circular mode, half_irq_o pulses for one cycle after the handshake at area offset H−1 (with H = floor(A/2) and H > 0), and again after the handshake at offset A−1, on every pass.
- R8: In circular mode, valid_o follows loop_en_i. While loop_en_i is low, the position is held, and raising loop_en_i again resumes from the held position.
- R9: A stop strobe makes valid_o low in the next cycle in either mode. It suppresses any done or half pulse, even when a handshake occurs in the same cycle.
- R10: A start strobe that arrives while the block is busy is ignored, and the running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Captures the configuration and begins a walk when idle |
| stop_i | input | 1 | Returns the block to idle at once |
| base_addr_i | input | AW | Start word address |
| line_len_i | input | LW | Words per line; 0 selects circular mode |
| stride_i | input | LW | Words between the starts of successive lines |
| line_cnt_i | input | CW | Number of lines minus one |
| loop_en_i | input | 1 | Lets circular mode advance when high |
| ready_i | input | 1 | Downstream accepts the current address |
| addr_o | output | AW | Current word address |
| valid_o | output | 1 | addr_o is presented |
| done_o | output | 1 | One-cycle completion pulse in block mode |
| half_irq_o | output | 1 | One-cycle half-area boundary pulse in circular mode |

## Verification
The properties assume three things about the inputs: start_i and stop_i are never high together, a circular-mode stride is at least 1, and the configuration inputs are meaningful only on the start cycle. The stimulus respects all three. It pulses each strobe alone, uses only non-zero strides in circular runs, and in the busy-start case changes the configuration on purpose to show that the change has no effect. Sweeps cover small lengths, strides and line counts under several ready patterns, an odd area size, a one-word area, a pause window, and a stop placed exactly on a half-boundary handshake.

// File: rtl/dma2d_pkg.sv
// Shared types for the 2D address sequencer.
package dma2d_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LINE = 2'd1,
        ST_RING = 2'd2
    } seq_state_t;
endpackage

// File: rtl/dma2d_ctrl.sv
// Mode controller: tracks idle/block/circular state and creates the done pulse.
// Assumes start_i and stop_i are not asserted together; stop has priority.
module dma2d_ctrl
    import dma2d_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       len_zero_i,
    input  logic       fire_i,
    input  logic       last_i,
    output seq_state_t state_o,
    output logic       load_o,
    output logic       done_o
);
    seq_state_t state_q;
    logic       done_q;

    assign load_o  = (state_q == ST_IDLE) && start_i && !stop_i;
    assign state_o = state_q;
    assign done_o  = done_q;

    // State transitions: stop wins, start only from idle, block ends on last word.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_i) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) state_q <= len_zero_i ? ST_RING : ST_LINE;
                ST_LINE: if (fire_i && last_i) state_q <= ST_IDLE;
                ST_RING: state_q <= ST_RING;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Completion pulse one cycle after the final block-mode handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= !stop_i && (state_q == ST_LINE) && fire_i && last_i;
    end
endmodule

// File: rtl/dma2d_walk.sv
// Block-mode walker: word-in-line and line counters plus the running line offset.
// Assumes len_i is non-zero whenever step_i is asserted.
module dma2d_walk #(
    parameter int AW = 16,
    parameter int LW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [LW-1:0] len_i,
    input  logic [LW-1:0] stride_i,
    input  logic [CW-1:0] cnt_i,
    output logic [AW-1:0] offset_o,
    output logic          last_o
);
    logic [LW-1:0] x_q;
    logic [CW-1:0] y_q;
    logic [AW-1:0] line_off_q;
    logic          end_of_line;

    assign end_of_line = (x_q == len_i - LW'(1));
    assign last_o      = end_of_line && (y_q == cnt_i);
    assign offset_o    = line_off_q + AW'(x_q);

    // Advance word, then line, on each accepted block-mode address.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            x_q        <= '0;
            y_q        <= '0;
            line_off_q <= '0;
        end else if (step_i) begin
            if (end_of_line) begin
                x_q        <= '0;
                y_q        <= y_q + CW'(1);
                line_off_q <= line_off_q + AW'(stride_i);
            end else begin
                x_q <= x_q + LW'(1);
            end
        end
    end
endmodule

// File: rtl/dma2d_ring.sv
// Circular-mode walker: area offset with wrap and half-boundary pulse.
// Assumes area_i >= 1 while stepping; half_i == 0 disables the mid pulse.
module dma2d_ring #(
    parameter int OW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic          stop_i,
    input  logic [OW-1:0] area_i,
    input  logic [OW-1:0] half_i,
    output logic [OW-1:0] offset_o,
    output logic          irq_o
);
    logic [OW-1:0] off_q;
    logic [OW-1:0] off_nxt;
    logic          irq_q;

    assign off_nxt  = off_q + OW'(1);
    assign offset_o = off_q;
    assign irq_o    = irq_q;

    // Offset counter: wraps to zero after the last word of the area.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i)  off_q <= '0;
        else if (step_i)       off_q <= (off_nxt == area_i) ? '0 : off_nxt;
    end

    // Boundary pulse after finishing either half; suppressed by stop.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= step_i && !stop_i && ((off_nxt == half_i) || (off_nxt == area_i));
    end
endmodule

// File: rtl/dma2d_addr_gen.sv
// Top of the 2D word address sequencer: captures the configuration on start,
// picks block or circular mode from the line length, and presents one
// address per handshake. Assumes a circular-mode stride of at least 1.
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [AW-1:0] base_addr_i,
    input  logic [LW-1:0] line_len_i,
    input  logic [LW-1:0] stride_i,
    input  logic [CW-1:0] line_cnt_i,
    input  logic          loop_en_i,
    input  logic          ready_i,
    output logic [AW-1:0] addr_o,
    output logic          valid_o,
    output logic          done_o,
    output logic          half_irq_o
);
    localparam int OW = LW + CW + 1;

    seq_state_t    state;
    logic          load;
    logic          fire;
    logic          last;
    logic [AW-1:0] base_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] stride_q;
    logic [CW-1:0] cnt_q;
    logic [OW-1:0] area;
    logic [OW-1:0] half;
    logic [AW-1:0] walk_off;
    logic [OW-1:0] ring_off;

    assign area    = OW'(stride_q) * (OW'(cnt_q) + OW'(1));
    assign half    = area >> 1;
    assign valid_o = (state == ST_LINE) || ((state == ST_RING) && loop_en_i);
    assign fire    = valid_o && ready_i;
    assign addr_o  = base_q + ((state == ST_RING) ? AW'(ring_off) : walk_off);

    // Configuration capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            len_q    <= '0;
            stride_q <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            base_q   <= base_addr_i;
            len_q    <= line_len_i;
            stride_q <= stride_i;
            cnt_q    <= line_cnt_i;
        end
    end

    dma2d_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .len_zero_i (line_len_i == '0),
        .fire_i     (fire),
        .last_i     (last),
        .state_o    (state),
        .load_o     (load),
        .done_o     (done_o)
    );

    dma2d_walk #(.AW(AW), .LW(LW), .CW(CW)) walk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (fire && (state == ST_LINE)),
        .len_i    (len_q),
        .stride_i (stride_q),
        .cnt_i    (cnt_q),
        .offset_o (walk_off),
        .last_o   (last)
    );

    dma2d_ring #(.OW(OW)) ring_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (fire && (state == ST_RING)),
        .stop_i   (stop_i),
        .area_i   (area),
        .half_i   (half),
        .offset_o (ring_off),
        .irq_o    (half_irq_o)
    );
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
// Port-level properties of the 2D address sequencer, bound to the top.
module dma2d_addr_gen_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stop_i,
    input logic          ready_i,
    input logic [AW-1:0] addr_o,
    input logic          valid_o,
    input logic          done_o,
    input logic          half_irq_o
);
    // R5: completion lasts one cycle.
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R5: completion follows a handshake.
    assert_done_after_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(valid_o && ready_i));
    // R5: nothing is presented once complete.
    assert_idle_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !valid_o);
    // R4: a stalled address is held.
    assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i && !stop_i) |=> $stable(addr_o));
    // R9: stop quiets every output next cycle.
    assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!valid_o && !done_o && !half_irq_o));
    // R7: boundary pulse follows a handshake.
    assert_irq_after_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        half_irq_o |-> $past(valid_o && ready_i));
    // R6: the two pulse kinds belong to different modes.
    assert_modes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && half_irq_o));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_i     (stop_i),
    .ready_i    (ready_i),
    .addr_o     (addr_o),
    .valid_o    (valid_o),
    .done_o     (done_o),
    .half_irq_o (half_irq_o)
);

// File: tb/dma2d_addr_gen_tb_top.sv
// Self-checking sweeps over block and circular modes of the address sequencer.
module dma2d_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        stop_i = 1'b0;
    logic [15:0] base_addr_i = '0;
    logic [7:0]  line_len_i = '0;
    logic [7:0]  stride_i = '0;
    logic [7:0]  line_cnt_i = '0;
    logic        loop_en_i = 1'b0;
    logic        ready_i = 1'b0;
    logic [15:0] addr_o;
    logic        valid_o;
    logic        done_o;
    logic        half_irq_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    dma2d_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .base_addr_i(base_addr_i), .line_len_i(line_len_i), .stride_i(stride_i),
        .line_cnt_i(line_cnt_i), .loop_en_i(loop_en_i), .ready_i(ready_i),
        .addr_o(addr_o), .valid_o(valid_o), .done_o(done_o), .half_irq_o(half_irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit pick(input int pat, input int cyc);
        if (pat == 0) return 1'b1;
        if (pat == 1) return cyc[0];
        return (cyc % 3) != 0;
    endfunction

    // Block-mode run; restart=1 pulses a conflicting start while busy (R10).
    task automatic run_line(input int base, input int len, input int stride,
                            input int cnt, input int pat, input bit restart);
        int total = len * (cnt + 1);
        int idx = 0;
        int cyc = 0;
        bit fin = 1'b0;
        string tag = restart ? "R10" : ((cnt == 0) ? "R2 R3" : "R2");
        base_addr_i = 16'(base); line_len_i = 8'(len);
        stride_i = 8'(stride); line_cnt_i = 8'(cnt);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!fin && cyc < 400) begin
            ready_i = pick(pat, cyc);
            if (restart && cyc == 1) begin
                start_i = 1'b1; base_addr_i = 16'(base + 700); line_len_i = 8'd1;
            end else begin
                start_i = 1'b0;
            end
            #1;
            if (idx == total) begin
                chk("R3 R5 done", int'(done_o), 1);
                chk("R5 valid after done", int'(valid_o), 0);
                fin = 1'b1;
            end else begin
                chk("R5 early done", int'(done_o), 0);
                chk("R4 valid", int'(valid_o), 1);
                chk(tag, int'(addr_o), (base + (idx / len) * stride + idx % len) & 16'hFFFF);
                if (ready_i) idx++;
            end
            cyc++;
            @(negedge clk);
        end
        ready_i = 1'b0;
        #1;
        chk("R5 single pulse", int'(done_o), 0);
        chk("R5 idle", int'(valid_o), 0);
        @(negedge clk);
    endtask

    // Circular run ending with a stop on the handshake at offset H-1 (or A-1).
    task automatic run_ring(input int base, input int s, input int c, input int pat);
        int area = s * (c + 1);
        int half = area / 2;
        int nfire = 2 * area + ((half > 0) ? half : area) - 1;
        int idx = 0;
        int cyc = 0;
        bit pend = 1'b0;
        bit en;
        base_addr_i = 16'(base); line_len_i = 8'd0;
        stride_i = 8'(s); line_cnt_i = 8'(c);
        loop_en_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (idx < nfire && cyc < 600) begin
            en = !(cyc >= 3 && cyc < 6);
            loop_en_i = en;
            ready_i = pick(pat, cyc);
            #1;
            chk("R7 half pulse", int'(half_irq_o), int'(pend));
            chk("R6 no done", int'(done_o), 0);
            chk("R8 valid follows enable", int'(valid_o), int'(en));
            if (valid_o) chk("R6 R8 ring address", int'(addr_o), (base + idx % area) & 16'hFFFF);
            pend = en && ready_i &&
                   (((idx % area) + 1 == half) || ((idx % area) + 1 == area));
            if (en && ready_i) idx++;
            cyc++;
            @(negedge clk);
        end
        loop_en_i = 1'b1; ready_i = 1'b1;
        #1;
        chk("R7 half pulse", int'(half_irq_o), int'(pend));
        chk("R7 boundary reached", int'(valid_o), 1);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0; ready_i = 1'b0;
        #1;
        chk("R9 valid after stop", int'(valid_o), 0);
        chk("R9 pulse suppressed", int'(half_irq_o), 0);
        chk("R9 no done", int'(done_o), 0);
        @(negedge clk);
        #1;
        chk("R9 stays idle", int'(valid_o), 0);
        loop_en_i = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 valid", int'(valid_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 irq", int'(half_irq_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 valid after release", int'(valid_o), 0);
        @(negedge clk);

        for (int len = 1; len <= 3; len++)
            for (int sv = 0; sv < 2; sv++)
                for (int cnt = 0; cnt <= 2; cnt++)
                    for (int pat = 0; pat < 3; pat++)
                        run_line(40 + len * 16, len, len + 3 * sv, cnt, pat, 1'b0);

        run_line(100, 2, 5, 1, 0, 1'b1);
        run_line(16'hFFFA, 3, 4, 2, 1, 1'b0);

        // R9: stop in block mode mid-run with a handshake on the stop cycle.
        base_addr_i = 16'd200; line_len_i = 8'd4; stride_i = 8'd4; line_cnt_i = 8'd2;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; ready_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0; ready_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk("R9 block stop valid", int'(valid_o), 0);
            chk("R9 block stop done", int'(done_o), 0);
            @(negedge clk);
        end

        run_ring(500, 1, 0, 0);
        run_ring(500, 3, 0, 0);
        run_ring(64, 2, 1, 1);
        run_ring(16'hFFF0, 3, 2, 2);
        run_ring(10, 5, 1, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule